// File: doc/BRIEF.md
# Serial Bit-String Search Engine

This engine walks a string of bits held in word-addressed memory and stops at the first bit whose value equals a chosen target (0 or 1). The scan runs either toward higher bit positions (upward) or toward lower ones (downward). A request supplies a byte address, a bit position inside the word at that address, a bit count and an initial value for a running counter of non-matching bits.

The engine reads one 32-bit word at a time through a simple request/wait memory port. It then tests one bit per clock inside the fetched word. It returns to memory only when the bit position crosses a word edge. When the scan ends, the engine reports the updated address, bit position, remaining count and miss counter, together with a zero flag. The zero flag stays high only if no matching bit was seen.

Top module: `bitscan_engine`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `done_o` and `mem_req_o` are low and `zero_o` is high.
- R2: When a request is accepted, the two low address bits are forced to zero and only bits [4:0] of `bitoff_i` are used as the starting bit position.
- R3: A request with `len_i` equal to zero makes no memory request and raises `done_o` in the next cycle. In that case `zero_o` is 1 and the count, counter and normalized position are unchanged.
- R4: A tested bit equal to the target (`find_one_i`=1 means target 1) clears `zero_o`. A tested bit that differs from the target adds one to the miss counter `skip_o`.
- R5: Every tested bit, the matching one included, moves the bit position by +1 (upward, `down_i`=0) or by −1 (downward, `down_i`=1) modulo 32, and lowers the remaining count by one.
- R6: When the bit position wraps from 31 to 0 (upward) or from 0 to 31 (downward), the address moves by +4 or −4. A new word is fetched only at such a wrap, and only if the scan continues.
- R7: The scan ends after the first matching bit, or when the remaining count reaches zero, whichever comes first.
- R8: While `mem_wait_i` is high during a request, `mem_req_o` stays high and `mem_addr_o` holds its value. The word is taken in the first cycle in which the request is high and the wait is low.
- R9: `done_o` is a one-cycle pulse. For a non-empty request it appears F+W+B+1 cycles after the accepting edge, where F is the number of fetches, W the number of wait cycles and B the number of bits tested.
- R10: A `start_i` pulse while the engine is busy is ignored, and so are changes to the request inputs at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Accept a request when idle |
| find_one_i | input | 1 | Target bit value |
| down_i | input | 1 | 1 = scan downward |
| addr_i | input | AW | Start byte address |
| bitoff_i | input | 8 | Start bit position (bits [4:0] used) |
| len_i | input | LW | Number of bits to scan |
| skip_i | input | CW | Initial miss counter |
| mem_req_o | output | 1 | Word read request |
| mem_addr_o | output | AW | Word-aligned read address |
| mem_wait_i | input | 1 | Memory not ready |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Completion pulse |
| zero_o | output | 1 | High while no match was found |
| addr_o | output | AW | Current address |
| bitoff_o | output | 5 | Current bit position |
| len_o | output | LW | Remaining bit count |
| skip_o | output | CW | Miss counter |

## Verification
The assertions check the following on every cycle:
- each tested bit updates the count and the miss counter, or clears the zero flag;
- the address stays word aligned;
- a stalled request holds both its request line and its address;
- a match leads straight to completion;
- `done_o` never lasts two cycles;
- an empty request never reaches memory.

Only the bench scenarios show the rest:
- the order of fetched addresses across upward and downward wraps, including the wrap below address zero;
- a match on the last bit of a word, which still advances the address without a fetch;
- the exact completion latency under wait states;
- that a mid-scan `start_i` changes nothing.

// File: rtl/bitscan_pkg.sv
// Package: shared constants and the controller state type of the bit-string
// search engine. Assumes 32-bit memory words.
package bitscan_pkg;
    localparam int WORD_BITS = 32;
    localparam int OFF_W     = $clog2(WORD_BITS);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SCAN  = 2'd2,
        ST_FIN   = 2'd3
    } scan_state_t;
endpackage

// File: rtl/bitscan_cursor.sv
// Module: bitscan_cursor
// Holds the scan position (address, bit position, remaining count), the miss
// counter, the zero flag and the fetched word. It decodes whether the current
// bit matches, whether the next step wraps the word, and whether it is the last
// bit. Assumes load_i, take_i and step_i are mutually exclusive.
module bitscan_cursor
    import bitscan_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 32,
    parameter int CW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 find_one_i,
    input  logic                 down_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [OFF_W-1:0]     off_i,
    input  logic [LW-1:0]        len_i,
    input  logic [CW-1:0]        skip_i,
    input  logic                 take_i,
    input  logic [WORD_BITS-1:0] word_i,
    input  logic                 step_i,
    output logic [AW-1:0]        addr_o,
    output logic [OFF_W-1:0]     off_o,
    output logic [LW-1:0]        len_o,
    output logic [CW-1:0]        skip_o,
    output logic                 zero_o,
    output logic                 hit_o,
    output logic                 wrap_o,
    output logic                 last_o
);
    localparam logic [AW-1:0]    WORD_STEP = AW'(WORD_BITS / 8);
    localparam logic [OFF_W-1:0] OFF_TOP   = OFF_W'(WORD_BITS - 1);

    logic [AW-1:0]        addr_q;
    logic [OFF_W-1:0]     off_q;
    logic [LW-1:0]        len_q;
    logic [CW-1:0]        skip_q;
    logic                 zero_q;
    logic                 target_q;
    logic                 down_q;
    logic [WORD_BITS-1:0] word_q;

    // Decode the current bit, the word-edge condition and the final-bit condition.
    always_comb begin
        hit_o  = (word_q[off_q] == target_q);
        wrap_o = down_q ? (off_q == '0) : (off_q == OFF_TOP);
        last_o = (len_q == LW'(1));
    end

    // Load, fetch capture and per-bit position update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            off_q    <= '0;
            len_q    <= '0;
            skip_q   <= '0;
            zero_q   <= 1'b1;
            target_q <= 1'b0;
            down_q   <= 1'b0;
            word_q   <= '0;
        end else if (load_i) begin
            addr_q   <= {addr_i[AW-1:2], 2'b00};
            off_q    <= off_i;
            len_q    <= len_i;
            skip_q   <= skip_i;
            zero_q   <= 1'b1;
            target_q <= find_one_i;
            down_q   <= down_i;
        end else begin
            if (take_i) begin
                word_q <= word_i;
            end
            if (step_i) begin
                if (hit_o) begin
                    zero_q <= 1'b0;
                end else begin
                    skip_q <= skip_q + CW'(1);
                end
                off_q <= down_q ? off_q - OFF_W'(1) : off_q + OFF_W'(1);
                len_q <= len_q - LW'(1);
                if (wrap_o) begin
                    addr_q <= down_q ? addr_q - WORD_STEP : addr_q + WORD_STEP;
                end
            end
        end
    end

    assign addr_o = addr_q;
    assign off_o  = off_q;
    assign len_o  = len_q;
    assign skip_o = skip_q;
    assign zero_o = zero_q;

    assert_len_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !load_i |=> len_o == $past(len_o) - LW'(1));
    assert_miss_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !load_i && !hit_o |=> skip_o == $past(skip_o) + CW'(1));
    assert_hit_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !load_i && hit_o |=> !zero_o);
    assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_o[1:0] == 2'b00);
endmodule

// File: rtl/bitscan_fsm.sv
// Module: bitscan_fsm
// Sequences a search: accept a request, fetch a word, test one bit per cycle,
// refetch at word edges, and pulse done. Assumes the memory delivers data in
// the first cycle where the request is high and wait is low.
module bitscan_fsm
    import bitscan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic empty_i,
    input  logic mem_wait_i,
    input  logic hit_i,
    input  logic wrap_i,
    input  logic last_i,
    output logic load_o,
    output logic take_o,
    output logic step_o,
    output logic mem_req_o,
    output logic done_o,
    output logic busy_o
);
    scan_state_t state_q, state_d;

    // Next-state and control decode.
    always_comb begin
        state_d   = state_q;
        load_o    = 1'b0;
        take_o    = 1'b0;
        step_o    = 1'b0;
        mem_req_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    load_o  = 1'b1;
                    state_d = empty_i ? ST_FIN : ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_req_o = 1'b1;
                if (!mem_wait_i) begin
                    take_o  = 1'b1;
                    state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                step_o = 1'b1;
                if (hit_i || last_i) begin
                    state_d = ST_FIN;
                end else if (wrap_i) begin
                    state_d = ST_FETCH;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign done_o = (state_q == ST_FIN);
    assign busy_o = (state_q != ST_IDLE);

    assert_wait_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_wait_i |=> mem_req_o);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_empty_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_o && empty_i |=> done_o && !mem_req_o);
    assert_match_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step_o && hit_i |=> done_o);
endmodule

// File: rtl/bitscan_engine.sv
// Module: bitscan_engine (top)
// Serial search of a memory bit string for the first bit equal to a target,
// upward or downward, counting missed bits. Connects the sequencer to the
// position datapath. Assumes the word at mem_addr_o appears on mem_rdata_i
// in the cycle the request is accepted.
module bitscan_engine
    import bitscan_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 32,
    parameter int CW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 find_one_i,
    input  logic                 down_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [7:0]           bitoff_i,
    input  logic [LW-1:0]        len_i,
    input  logic [CW-1:0]        skip_i,
    output logic                 mem_req_o,
    output logic [AW-1:0]        mem_addr_o,
    input  logic                 mem_wait_i,
    input  logic [WORD_BITS-1:0] mem_rdata_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 zero_o,
    output logic [AW-1:0]        addr_o,
    output logic [OFF_W-1:0]     bitoff_o,
    output logic [LW-1:0]        len_o,
    output logic [CW-1:0]        skip_o
);
    logic load, take, step, hit, wrap, last;

    bitscan_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .empty_i    (len_i == '0),
        .mem_wait_i (mem_wait_i),
        .hit_i      (hit),
        .wrap_i     (wrap),
        .last_i     (last),
        .load_o     (load),
        .take_o     (take),
        .step_o     (step),
        .mem_req_o  (mem_req_o),
        .done_o     (done_o),
        .busy_o     (busy_o)
    );

    bitscan_cursor #(.AW(AW), .LW(LW), .CW(CW)) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .find_one_i (find_one_i),
        .down_i     (down_i),
        .addr_i     (addr_i),
        .off_i      (bitoff_i[OFF_W-1:0]),
        .len_i      (len_i),
        .skip_i     (skip_i),
        .take_i     (take),
        .word_i     (mem_rdata_i),
        .step_i     (step),
        .addr_o     (addr_o),
        .off_o      (bitoff_o),
        .len_o      (len_o),
        .skip_o     (skip_o),
        .zero_o     (zero_o),
        .hit_o      (hit),
        .wrap_o     (wrap),
        .last_o     (last)
    );

    assign mem_addr_o = addr_o;

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_wait_i |=> $stable(mem_addr_o));
endmodule

// File: tb/bitscan_engine_bench.sv
// Bench: behavioural search model per request, checked on every clock.
module bitscan_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, find_one_i = 1'b0, down_i = 1'b0;
    logic [31:0] addr_i = '0, len_i = '0, skip_i = '0;
    logic [7:0]  bitoff_i = '0;
    logic        mem_req_o, mem_wait_i = 1'b0;
    logic [31:0] mem_addr_o, mem_rdata_i;
    logic        busy_o, done_o, zero_o;
    logic [31:0] addr_o, len_o, skip_o;
    logic [4:0]  bitoff_o;

    logic [31:0] mem [64];
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always_comb mem_rdata_i = mem[mem_addr_o[7:2]];

    bitscan_engine u_bitscan_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .find_one_i(find_one_i),
        .down_i(down_i), .addr_i(addr_i), .bitoff_i(bitoff_i), .len_i(len_i),
        .skip_i(skip_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_wait_i(mem_wait_i), .mem_rdata_i(mem_rdata_i), .busy_o(busy_o),
        .done_o(done_o), .zero_o(zero_o), .addr_o(addr_o), .bitoff_o(bitoff_o),
        .len_o(len_o), .skip_o(skip_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One request: model the expected result, then follow the engine cycle by cycle.
    task automatic run(input bit val, input bit dn, input logic [31:0] a, input logic [7:0] off,
                       input int len, input int skip, input int wmode, input bit poke);
        logic [31:0] q[$];
        logic [31:0] ea;
        int eo, el, es, nf, nb, nw, n, wrun;
        bit ez, wrapped, seen;
        ea = a & 32'hFFFF_FFFC; eo = off & 31; el = len; es = skip; ez = 1'b1;
        nf = 0; nb = 0;
        if (el != 0) begin
            q.push_back(ea); nf++;
            forever begin
                nb++;
                if (mem[ea[7:2]][eo] == val) ez = 1'b0; else es++;
                eo = dn ? (eo + 31) % 32 : (eo + 1) % 32;
                el--;
                wrapped = dn ? (eo == 31) : (eo == 0);
                if (wrapped) ea = dn ? ea - 32'd4 : ea + 32'd4;
                if (!ez || el == 0) break;
                if (wrapped) begin q.push_back(ea); nf++; end
            end
        end
        @(negedge clk);
        find_one_i = val; down_i = dn; addr_i = a; bitoff_i = off;
        len_i = len; skip_i = skip; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 1; nw = 0; wrun = 0; seen = 1'b0;
        while (!seen) begin
            if (n > 3000) begin
                chk(1'b0, "R9 watchdog", n, 0);
                break;
            end
            if (done_o) begin
                seen = 1'b1;
                chk(n == nf + nw + nb + 1, "R9 latency", n, nf + nw + nb + 1);
                chk(addr_o == ea, "R2/R6 addr", addr_o, ea);
                chk(bitoff_o == eo[4:0], "R5 offset", bitoff_o, eo);
                chk(len_o == el, "R7 length", len_o, el);
                chk(skip_o == es, "R4 skip", skip_o, es);
                chk(zero_o == ez, "R4 zero", zero_o, ez);
                chk(q.size() == 0, (len == 0) ? "R3 fetch" : "R6 fetch", q.size(), 0);
            end else begin
                chk(busy_o == 1'b1, "R9 busy", busy_o, 1);
                if (poke && n == 2) begin
                    start_i = 1'b1; addr_i = 32'h0000_00FC; bitoff_i = 8'd3; len_i = 32'd7;
                    find_one_i = ~val;
                end
                if (poke && n == 3) start_i = 1'b0;
                if (mem_req_o && wmode != 0 && wrun < 2) begin
                    mem_wait_i = 1'b1; wrun++;
                end else begin
                    mem_wait_i = 1'b0;
                    if (!mem_req_o) wrun = 0;
                end
                if (mem_req_o && mem_wait_i) nw++;
                if (mem_req_o && !mem_wait_i) begin
                    wrun = 0;
                    if (q.size() == 0) chk(1'b0, (len == 0) ? "R3 extra fetch" : "R6 extra fetch", mem_addr_o, 0);
                    else begin
                        chk(mem_addr_o == q[0], (wmode != 0) ? "R8 fetch addr" : "R6 fetch addr", mem_addr_o, q[0]);
                        void'(q.pop_front());
                    end
                end
                @(negedge clk);
                n++;
            end
        end
        mem_wait_i = 1'b0;
        @(negedge clk);
        chk(!done_o, "R9 pulse", done_o, 0);
        chk(!busy_o, poke ? "R10 idle" : "R9 idle", busy_o, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        mem[0]  = 32'h0000_0100;
        mem[4]  = 32'hFFFF_FFFF;
        mem[5]  = 32'hFFFF_FFEF;
        mem[8]  = 32'h8000_0000;
        mem[16] = 32'h8000_0000;
        mem[20] = 32'h0000_0001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !mem_req_o, "R1 idle", {busy_o, done_o, mem_req_o}, 0);
        chk(zero_o == 1'b1, "R1 zero", zero_o, 1);
        run(1'b1, 1'b0, 32'h0000_0003, 8'hE0, 40, 5, 0, 1'b0);   // R2 masking, hit at bit 8
        run(1'b0, 1'b0, 32'h0000_0012, 8'd20, 100, 0, 1, 1'b0);  // R6/R8 upward wrap with waits
        run(1'b1, 1'b1, 32'h0000_0024, 8'd3, 60, 2, 0, 1'b0);    // downward wrap, hit at bit 31
        run(1'b1, 1'b0, 32'h0000_0030, 8'd5, 10, 1, 0, 1'b0);    // R7 count exhausted
        run(1'b1, 1'b0, 32'h0000_0044, 8'd9, 0, 3, 0, 1'b0);     // R3 empty request
        run(1'b1, 1'b0, 32'h0000_0040, 8'd28, 50, 0, 1, 1'b0);   // hit on last bit of word
        run(1'b1, 1'b1, 32'h0000_0000, 8'd1, 5, 0, 1, 1'b0);     // downward wrap below zero
        run(1'b1, 1'b1, 32'h0000_0050, 8'd20, 40, 0, 1, 1'b1);   // R10 start while busy
        run(1'b0, 1'b0, 32'h0000_0010, 8'd0, 32, 7, 0, 1'b0);    // whole word, no zero found
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule